// File: doc/BRIEF.md
# Supply Brown-out Reset Controller

This block is the digital control that sits behind a supply-voltage monitor. Each clock it receives a digitized supply sample in millivolts. It decides whether the monitor is enabled, picks the threshold to compare against and filters short dips with a consecutive-cycle debounce. When a dip is confirmed it raises a reset request, which is held with hysteresis, and it sends a one-cycle re-arm pulse to the power-on reset circuit.

The monitor's enable policy comes from a two-bit configuration field. The field selects one of four policies: never on, gated by a software-writable bit, on except during sleep, or always on. A separate two-bit power field picks one of three trip-and-reset modes or a zero-power mode. The zero-power mode only re-arms power-on reset and never requests a reset. Two status flags let software tell a brown-out apart from a power-on reset. The BOR flag is cleared by either kind of event, while the POR flag is cleared only by power-on reset. Both flags are set again by software.

Top module: `bor_ctrl`

## Requirements
- R1: `mon_en` follows `cfg_en_mode` in the same cycle: code 00 gives 0, code 01 gives the software enable bit, code 10 gives the inverse of `sleep_i`, and code 11 gives 1.
- R2: The software enable bit resets to 0. It takes `sw_en_wdata` on the clock edge where `sw_en_wr` is high, but only while `cfg_en_mode` is 01. In any other mode it is forced to 0 and writes are ignored. `sw_en_rd` shows the bit from the cycle after the edge.
- R3: With `cfg_pwr_mode` 00 (high), 01 (medium) or 10 (low), the threshold depends on `cfg_trip_sel`. Code 00 selects 3000 mV, 01 selects 2700 mV, 10 selects 2000 mV and 11 selects 1800 mV.
- R4: A trip is recognised on the clock edge that completes DEB_CYCLES consecutive enabled edges (16 by default) with `vdd_mv` strictly below the threshold. Any edge at or above the threshold restarts the count. In a reset-capable power mode, `bor_rst_req` is high from that edge.
- R5: Once tripped, `bor_rst_req` stays high until an edge sees `vdd_mv` at or above the threshold plus 50 mV. It is low from that edge on.
- R6: With `cfg_pwr_mode` 11 (zero power), the threshold is fixed at 2000 mV whatever `cfg_trip_sel` says, and `bor_rst_req` is never asserted.
- R7: Every recognised trip, in any power mode, produces a `por_rearm` pulse exactly one cycle long, starting at the trip edge.
- R8: While `mon_en` is 0, the debounce count and the tripped state are cleared at each edge, and `bor_rst_req` and `por_rearm` are 0. After re-enabling, a full DEB_CYCLES run is needed to trip.
- R9: `stat_bor` resets to 0. It is cleared at any edge where `por_evt_i` or `bor_rst_req` is high. Otherwise it is set at an edge where `set_bor_i` is high, so clearing wins over setting.
- R10: `stat_por` resets to 0. It is cleared at any edge where `por_evt_i` is high. Otherwise it is set at an edge where `set_por_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_mv | input | 12 | Digitized supply sample, millivolts |
| cfg_en_mode | input | 2 | Enable policy: 00 off, 01 software, 10 on except sleep, 11 on |
| cfg_pwr_mode | input | 2 | Power mode: 00 high, 01 medium, 10 low, 11 zero |
| cfg_trip_sel | input | 2 | Trip level code |
| sw_en_wr | input | 1 | Write strobe for the software enable bit |
| sw_en_wdata | input | 1 | Value written to the software enable bit |
| sleep_i | input | 1 | Device is in sleep |
| por_evt_i | input | 1 | Power-on reset event |
| set_por_i | input | 1 | Software sets the POR flag |
| set_bor_i | input | 1 | Software sets the BOR flag |
| mon_en | output | 1 | Monitor enabled |
| sw_en_rd | output | 1 | Readback of the software enable bit |
| bor_rst_req | output | 1 | Brown-out reset request |
| por_rearm | output | 1 | One-cycle power-on reset re-arm pulse |
| stat_por | output | 1 | POR status flag |
| stat_bor | output | 1 | BOR status flag |

## Verification
`mon_en` is combinational, so it is due in the same cycle as a change to the enable field or to sleep. The software bit and both flags are due one edge after the write or event. `bor_rst_req` and `por_rearm` rise on the edge that completes the debounce run, and `bor_rst_req` falls on the edge that sees the release level. The bench changes inputs just after the falling edge and compares a short time later, once combinational paths have settled. It then advances its reference state at the rising edge, using the same inputs the design saw. Every expected value therefore refers to exactly the edges already taken.

// File: rtl/bor_pkg.sv
package bor_pkg;
    typedef enum logic [1:0] {
        EN_NEVER   = 2'b00,
        EN_SW      = 2'b01,
        EN_NOSLEEP = 2'b10,
        EN_ALWAYS  = 2'b11
    } en_mode_e;

    typedef enum logic [1:0] {
        PWR_HIGH = 2'b00,
        PWR_MED  = 2'b01,
        PWR_LOW  = 2'b10,
        PWR_ZERO = 2'b11
    } pwr_mode_e;
endpackage

// File: rtl/bor_enable_ctrl.sv
module bor_enable_ctrl
    import bor_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  en_mode_e en_mode,
    input  logic     sw_wr,
    input  logic     sw_wdata,
    input  logic     sleep,
    output logic     mon_en,
    output logic     sw_rd
);
    typedef struct packed {
        logic sw;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_mode != EN_SW) begin
            st_d.sw = 1'b0;
        end else if (sw_wr) begin
            st_d.sw = sw_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (en_mode)
            EN_NEVER:   mon_en = 1'b0;
            EN_SW:      mon_en = st_q.sw;
            EN_NOSLEEP: mon_en = ~sleep;
            default:    mon_en = 1'b1;
        endcase
    end

    assign sw_rd = st_q.sw;

    // R2
    sw_bit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mode != EN_SW) |=> !sw_rd);
endmodule

// File: rtl/bor_level_sel.sv
module bor_level_sel
    import bor_pkg::*;
#(
    parameter int VW      = 12,
    parameter int LVL0_MV = 3000,
    parameter int LVL1_MV = 2700,
    parameter int LVL2_MV = 2000,
    parameter int LVL3_MV = 1800,
    parameter int ZP_MV   = 2000
) (
    input  logic [1:0]    trip_sel,
    input  pwr_mode_e     pwr_mode,
    output logic [VW-1:0] thr_mv,
    output logic          zero_pwr
);
    localparam logic [VW-1:0] L0 = VW'(LVL0_MV);
    localparam logic [VW-1:0] L1 = VW'(LVL1_MV);
    localparam logic [VW-1:0] L2 = VW'(LVL2_MV);
    localparam logic [VW-1:0] L3 = VW'(LVL3_MV);
    localparam logic [VW-1:0] LZ = VW'(ZP_MV);

    logic [VW-1:0] sel_mv;

    always_comb begin
        unique case (trip_sel)
            2'b00:   sel_mv = L0;
            2'b01:   sel_mv = L1;
            2'b10:   sel_mv = L2;
            default: sel_mv = L3;
        endcase
    end

    assign zero_pwr = (pwr_mode == PWR_ZERO);
    assign thr_mv   = zero_pwr ? LZ : sel_mv;
endmodule

// File: rtl/bor_trip_det.sv
module bor_trip_det #(
    parameter int VW         = 12,
    parameter int DEB_CYCLES = 16,
    parameter int HYST_MV    = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mon_en,
    input  logic [VW-1:0] vdd_mv,
    input  logic [VW-1:0] thr_mv,
    input  logic          zero_pwr,
    output logic          rst_req,
    output logic          rearm
);
    localparam int             CW     = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0]  LAST_C = CW'(DEB_CYCLES - 1);
    localparam logic [VW:0]    HYST_C = (VW+1)'(HYST_MV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          trip;
        logic          rearm;
    } det_state_t;

    det_state_t st_d, st_q;
    logic below, release_ok;

    assign below      = {1'b0, vdd_mv} <  {1'b0, thr_mv};
    assign release_ok = {1'b0, vdd_mv} >= ({1'b0, thr_mv} + HYST_C);

    always_comb begin
        st_d       = st_q;
        st_d.rearm = 1'b0;
        if (!mon_en) begin
            st_d.cnt  = '0;
            st_d.trip = 1'b0;
        end else if (st_q.trip) begin
            st_d.cnt = '0;
            if (release_ok) st_d.trip = 1'b0;
        end else if (below) begin
            if (st_q.cnt == LAST_C) begin
                st_d.cnt   = '0;
                st_d.trip  = 1'b1;
                st_d.rearm = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.trip & mon_en & ~zero_pwr;
    assign rearm   = st_q.rearm & mon_en;

    // R7
    rearm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rearm |=> !st_q.rearm);
    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (st_q.cnt == '0 && !st_q.trip));
    // R4
    trip_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.trip) |-> $past(below && mon_en));
    // R5
    hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trip && mon_en && !release_ok) |=> st_q.trip);
endmodule

// File: rtl/bor_status.sv
module bor_status (
    input  logic clk,
    input  logic rst_n,
    input  logic por_evt,
    input  logic bor_evt,
    input  logic set_por,
    input  logic set_bor,
    output logic por_flag,
    output logic bor_flag
);
    typedef struct packed {
        logic por;
        logic bor;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_evt)      st_d.por = 1'b0;
        else if (set_por) st_d.por = 1'b1;
        if (por_evt || bor_evt) st_d.bor = 1'b0;
        else if (set_bor)       st_d.bor = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign por_flag = st_q.por;
    assign bor_flag = st_q.bor;

    // R9
    bor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_evt || bor_evt) |=> !bor_flag);
    // R10
    por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> !por_flag);
endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
    import bor_pkg::*;
#(
    parameter int VW         = 12,
    parameter int DEB_CYCLES = 16,
    parameter int HYST_MV    = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vdd_mv,
    input  logic [1:0]    cfg_en_mode,
    input  logic [1:0]    cfg_pwr_mode,
    input  logic [1:0]    cfg_trip_sel,
    input  logic          sw_en_wr,
    input  logic          sw_en_wdata,
    input  logic          sleep_i,
    input  logic          por_evt_i,
    input  logic          set_por_i,
    input  logic          set_bor_i,
    output logic          mon_en,
    output logic          sw_en_rd,
    output logic          bor_rst_req,
    output logic          por_rearm,
    output logic          stat_por,
    output logic          stat_bor
);
    logic [VW-1:0] thr_mv;
    logic          zero_pwr;

    bor_enable_ctrl u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_mode  (en_mode_e'(cfg_en_mode)),
        .sw_wr    (sw_en_wr),
        .sw_wdata (sw_en_wdata),
        .sleep    (sleep_i),
        .mon_en   (mon_en),
        .sw_rd    (sw_en_rd)
    );

    bor_level_sel #(.VW(VW)) u_level (
        .trip_sel (cfg_trip_sel),
        .pwr_mode (pwr_mode_e'(cfg_pwr_mode)),
        .thr_mv   (thr_mv),
        .zero_pwr (zero_pwr)
    );

    bor_trip_det #(.VW(VW), .DEB_CYCLES(DEB_CYCLES), .HYST_MV(HYST_MV)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_en   (mon_en),
        .vdd_mv   (vdd_mv),
        .thr_mv   (thr_mv),
        .zero_pwr (zero_pwr),
        .rst_req  (bor_rst_req),
        .rearm    (por_rearm)
    );

    bor_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_evt  (por_evt_i),
        .bor_evt  (bor_rst_req),
        .set_por  (set_por_i),
        .set_bor  (set_bor_i),
        .por_flag (stat_por),
        .bor_flag (stat_bor)
    );

    // R6
    zero_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pwr_mode == 2'b11) |-> !bor_rst_req);
    // R1
    never_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_mode == 2'b00) |-> (!mon_en && !por_rearm));
endmodule

// File: tb/bor_ctrl_bench.sv
module bor_ctrl_bench;
    localparam int DEB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] vdd_mv = 12'd3300;
    logic [1:0]  cfg_en_mode = 2'b11;
    logic [1:0]  cfg_pwr_mode = 2'b00;
    logic [1:0]  cfg_trip_sel = 2'b00;
    logic        sw_en_wr = 1'b0, sw_en_wdata = 1'b0, sleep_i = 1'b0;
    logic        por_evt_i = 1'b0, set_por_i = 1'b0, set_bor_i = 1'b0;
    logic        mon_en, sw_en_rd, bor_rst_req, por_rearm, stat_por, stat_bor;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    bit m_sw = 0, m_trip = 0, m_rearm = 0, m_por = 0, m_bor = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    bor_ctrl u_bor_ctrl (
        .clk(clk), .rst_n(rst_n), .vdd_mv(vdd_mv),
        .cfg_en_mode(cfg_en_mode), .cfg_pwr_mode(cfg_pwr_mode), .cfg_trip_sel(cfg_trip_sel),
        .sw_en_wr(sw_en_wr), .sw_en_wdata(sw_en_wdata), .sleep_i(sleep_i),
        .por_evt_i(por_evt_i), .set_por_i(set_por_i), .set_bor_i(set_bor_i),
        .mon_en(mon_en), .sw_en_rd(sw_en_rd), .bor_rst_req(bor_rst_req),
        .por_rearm(por_rearm), .stat_por(stat_por), .stat_bor(stat_bor)
    );

    function automatic bit exp_mon();
        case (cfg_en_mode)
            2'b00:   return 1'b0;
            2'b01:   return m_sw;
            2'b10:   return !sleep_i;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int exp_thr();
        if (cfg_pwr_mode == 2'b11) return 2000;
        case (cfg_trip_sel)
            2'b00:   return 3000;
            2'b01:   return 2700;
            2'b10:   return 2000;
            default: return 1800;
        endcase
    endfunction

    function automatic bit exp_rst();
        return m_trip && exp_mon() && (cfg_pwr_mode != 2'b11);
    endfunction

    function automatic bit exp_rearm();
        return m_rearm && exp_mon();
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1 mon_en", mon_en, exp_mon());
        check("R2 sw_en_rd", sw_en_rd, m_sw);
        check("R4 R5 R6 bor_rst_req", bor_rst_req, exp_rst());
        check("R7 por_rearm", por_rearm, exp_rearm());
        check("R9 stat_bor", stat_bor, m_bor);
        check("R10 stat_por", stat_por, m_por);
    endtask

    task automatic model_step();
        bit mon, rst_now, n_trip, n_rearm, n_sw;
        int n_cnt, thr;
        mon     = exp_mon();
        rst_now = exp_rst();
        thr     = exp_thr();
        n_trip  = m_trip;
        n_rearm = 0;
        n_cnt   = m_cnt;
        if (!mon) begin
            n_cnt = 0; n_trip = 0;
        end else if (m_trip) begin
            n_cnt = 0;
            if (int'(vdd_mv) >= thr + 50) n_trip = 0;
        end else if (int'(vdd_mv) < thr) begin
            if (m_cnt == DEB - 1) begin
                n_cnt = 0; n_trip = 1; n_rearm = 1;
            end else n_cnt = m_cnt + 1;
        end else n_cnt = 0;
        n_sw = m_sw;
        if (cfg_en_mode != 2'b01) n_sw = 0;
        else if (sw_en_wr) n_sw = sw_en_wdata;
        if (por_evt_i) m_por = 0; else if (set_por_i) m_por = 1;
        if (por_evt_i || rst_now) m_bor = 0; else if (set_bor_i) m_bor = 1;
        m_sw = n_sw; m_trip = n_trip; m_rearm = n_rearm; m_cnt = n_cnt;
    endtask

    // inputs are set just after a falling edge before this is called
    task automatic run_cycle();
        #2;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic hold(int n);
        for (int i = 0; i < n; i++) run_cycle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_b0a7));
        repeat (3) @(negedge clk);
        // reset state
        check("R9 reset stat_bor", stat_bor, 1'b0);
        check("R10 reset stat_por", stat_por, 1'b0);
        check("R4 reset bor_rst_req", bor_rst_req, 1'b0);
        check("R2 reset sw_en_rd", sw_en_rd, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // flags set by software
        set_por_i = 1; set_bor_i = 1; run_cycle();
        set_por_i = 0; set_bor_i = 0; hold(3);

        // R4: one short of the debounce run does not trip
        vdd_mv = 12'd2900; hold(DEB - 1);
        check("R4 short dip", bor_rst_req, 1'b0);
        vdd_mv = 12'd3100; hold(2);
        // R4 and R7: a full run trips
        vdd_mv = 12'd2900; hold(DEB);
        check("R4 full dip", bor_rst_req, 1'b1);
        check("R7 rearm at trip", por_rearm, 1'b1);
        check("R9 bor flag kept until edge", stat_bor, 1'b1);
        hold(1);
        check("R7 rearm one cycle", por_rearm, 1'b0);
        check("R9 bor flag cleared by trip", stat_bor, 1'b0);
        check("R10 por flag kept by brown-out", stat_por, 1'b1);
        // R5: hysteresis
        vdd_mv = 12'd3049; hold(4);
        check("R5 below release", bor_rst_req, 1'b1);
        vdd_mv = 12'd3050; hold(1);
        check("R5 at release", bor_rst_req, 1'b0);

        // R3: 1800 mV level
        cfg_trip_sel = 2'b11; vdd_mv = 12'd1850; hold(DEB + 2);
        check("R3 above 1800", bor_rst_req, 1'b0);
        vdd_mv = 12'd1790; hold(DEB);
        check("R3 below 1800", bor_rst_req, 1'b1);
        vdd_mv = 12'd3100; hold(3);

        // R6: zero power uses 2000 mV, re-arm only
        cfg_pwr_mode = 2'b11; cfg_trip_sel = 2'b00; vdd_mv = 12'd2100; hold(DEB + 2);
        check("R6 ignores trip code", por_rearm, 1'b0);
        vdd_mv = 12'd1990; hold(DEB);
        check("R6 rearm", por_rearm, 1'b1);
        check("R6 no reset", bor_rst_req, 1'b0);
        vdd_mv = 12'd3100; hold(3);

        // R8: disabled monitor keeps counter clear
        cfg_pwr_mode = 2'b00; cfg_en_mode = 2'b00; vdd_mv = 12'd1000; hold(40);
        check("R8 disabled", bor_rst_req, 1'b0);
        cfg_en_mode = 2'b11; hold(DEB - 1);
        check("R8 fresh count", bor_rst_req, 1'b0);
        hold(1);
        check("R8 full count", bor_rst_req, 1'b1);
        vdd_mv = 12'd3300; hold(2);

        // R2 and R1: software bit only in mode 01, sleep gating in mode 10
        cfg_en_mode = 2'b10; sw_en_wr = 1; sw_en_wdata = 1; run_cycle();
        sw_en_wr = 0; hold(1);
        check("R2 write ignored", sw_en_rd, 1'b0);
        sleep_i = 1; #2;
        check("R1 sleep off", mon_en, 1'b0);
        hold(1);
        sleep_i = 0;
        cfg_en_mode = 2'b01; sw_en_wr = 1; sw_en_wdata = 1; run_cycle();
        sw_en_wr = 0; hold(1);
        check("R2 write taken", sw_en_rd, 1'b1);
        check("R1 software on", mon_en, 1'b1);

        // por event clears both flags
        set_por_i = 1; set_bor_i = 1; run_cycle();
        set_por_i = 0; set_bor_i = 0; por_evt_i = 1; run_cycle();
        por_evt_i = 0; hold(1);
        check("R10 por event", stat_por, 1'b0);
        check("R9 por event", stat_bor, 1'b0);

        // constrained random
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(0, 19) == 0) begin
                case ($urandom_range(0, 10))
                    0: vdd_mv = 12'd3100;  1: vdd_mv = 12'd2960;
                    2: vdd_mv = 12'd2760;  3: vdd_mv = 12'd2690;
                    4: vdd_mv = 12'd2040;  5: vdd_mv = 12'd1990;
                    6: vdd_mv = 12'd1840;  7: vdd_mv = 12'd1790;
                    8: vdd_mv = 12'd1500;  9: vdd_mv = 12'd3050;
                    default: vdd_mv = 12'd2060;
                endcase
            end
            if ($urandom_range(0, 199) == 0) cfg_en_mode  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 199) == 0) cfg_pwr_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 199) == 0) cfg_trip_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 29) == 0) sleep_i = ~sleep_i;
            sw_en_wr    = ($urandom_range(0, 39) == 0);
            sw_en_wdata = 1'($urandom_range(0, 1));
            por_evt_i   = ($urandom_range(0, 299) == 0);
            set_por_i   = ($urandom_range(0, 24) == 0);
            set_bor_i   = ($urandom_range(0, 24) == 0);
            run_cycle();
        end
        finish_run();
    end
endmodule